// File: doc/BRIEF.md
# Translation Entry Checker

This block judges one 64-bit entry of a second-level address translation table. The walker that fetched the entry also supplies its table level (1 to 4) and two enable inputs. One enable says whether large pages may be used at levels 2 and 3. The other says whether a not-present fault may be turned into a convertible violation. The block also takes a reserved-bit mask for each level. It returns a single outcome code and a convertible flag. The walker uses the code to decide whether to descend, stop with a mapping, or raise a fault. The block never reads memory and never combines attributes across levels.

The outcome is produced in one combinational step. A parameter selects whether a single register stage sits behind that step, so the result can follow the input in the same cycle or one clock later.

Top module: `xlat_entry_checker`

## Requirements
- R1: Bits 2:0 of the entry are read, write and execute. An entry is present when any of these three bits is set. When none is set, the outcome is ABSENT (code 0), whatever the other bits hold.
- R2: A present entry with read clear and write or execute set gives outcome MISCFG (code 1). A present entry with read set passes the permission check.
- R3: An entry maps memory (a leaf) when its level is 1, or when its level is 2 or 3 and bit 7 (the large-page bit) is set.
- R4: On a leaf, the memory-type field in bits 5:3 must be 0, 1, 4, 5 or 6. The values 2, 3 and 7 give MISCFG. On a non-leaf entry the field is ignored.
- R5: The mask input holds four 64-bit slices, and level L uses bits 64*L-1 down to 64*(L-1). When a present entry has any bit set that is also set in its level's slice, the outcome is MISCFG.
- R6: Bit 7 set at level 4 gives MISCFG. Bit 7 set at level 2 or 3 while the large-page enable is low also gives MISCFG. At level 1, bit 7 is ignored.
- R7: A present entry whose level is 0 or greater than 4 gives MISCFG.
- R8: The convertible flag is 1 only when all of these hold: the outcome is ABSENT, the feature enable is high, the entry has level 1 or bit 7 set, and bit 63 (the suppress bit) is clear. In every other case the flag is 0.
- R9: A present entry with no misconfiguration gives LEAF (code 3) if it is a leaf, and TABLE (code 2) otherwise.
- R10: ABSENT takes priority over every misconfiguration check.
- R11: With the output register enabled (the default), each result appears one clock after its inputs. While reset is held, the outputs are ABSENT with the convertible flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low synchronous reset |
| entry_i | input | 64 | Table entry under test |
| level_i | input | 3 | Table level of the entry, 1 to 4 |
| feat_en_i | input | 1 | Enables convertible violations |
| big_ok_i | input | 1 | Large pages allowed at levels 2 and 3 |
| rsvd_mask_i | input | 256 | Reserved-bit masks, one 64-bit slice per level |
| outcome_o | output | 2 | 0 ABSENT, 1 MISCFG, 2 TABLE, 3 LEAF |
| convertible_o | output | 1 | The not-present fault is of the convertible kind |

## Verification
The hardest cases to reach are the ones where several checks could fire on the same entry. Examples are a not-present entry that also has reserved bits set, and a large-page entry at level 4 whose memory-type field would be legal. Only the priority order decides the outcome of these. The stimulus table builds each of these entries on purpose, choosing the entry bits and the per-level masks so that exactly two checks compete. The table also sweeps all eight memory-type values on a level-1 leaf.

// File: rtl/xec_pkg.sv
package xec_pkg;

    typedef enum logic [1:0] {
        XEC_ABSENT = 2'd0,
        XEC_MISCFG = 2'd1,
        XEC_TABLE  = 2'd2,
        XEC_LEAF   = 2'd3
    } xec_code_e;

    typedef struct packed {
        xec_code_e code;
        logic      conv;
    } xec_res_t;

    // legal memory-type encodings: 0,1,4,5,6
    localparam logic [7:0] XEC_MT_LEGAL = 8'b0111_0011;

endpackage

// File: rtl/xec_perm.sv
module xec_perm #(
    parameter int RD_BIT = 0,
    parameter int WR_BIT = 1,
    parameter int EX_BIT = 2
) (
    input  logic [2:0] perm_i,
    output logic       present_o,
    output logic       perm_bad_o
);
    always_comb begin
        present_o  = perm_i[RD_BIT] | perm_i[WR_BIT] | perm_i[EX_BIT];
        perm_bad_o = !perm_i[RD_BIT] && (perm_i[WR_BIT] || perm_i[EX_BIT]);
    end
endmodule

// File: rtl/xec_leaf.sv
module xec_leaf #(
    parameter int          LEVELS     = 4,
    parameter int          LVL_W      = 3,
    parameter int          LP_MIN_LVL = 2,
    parameter int          LP_MAX_LVL = 3,
    parameter int          MT_W       = 3,
    parameter logic [(1<<MT_W)-1:0] MT_LEGAL = 8'b0111_0011
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic             lp_bit_i,
    input  logic [MT_W-1:0]  mtype_i,
    input  logic             big_ok_i,
    output logic             leaf_any_o,
    output logic             leaf_map_o,
    output logic             mt_bad_o,
    output logic             lp_bad_o,
    output logic             lvl_bad_o
);
    logic lvl_one;
    logic lvl_big;
    logic lvl_top;

    always_comb begin
        lvl_one    = (level_i == LVL_W'(1));
        lvl_big    = (level_i >= LVL_W'(LP_MIN_LVL)) && (level_i <= LVL_W'(LP_MAX_LVL));
        lvl_top    = (level_i == LVL_W'(LEVELS));
        lvl_bad_o  = (level_i == '0) || (level_i > LVL_W'(LEVELS));
        leaf_any_o = lvl_one || lp_bit_i;
        leaf_map_o = lvl_one || (lvl_big && lp_bit_i);
        mt_bad_o   = leaf_map_o && !MT_LEGAL[mtype_i];
        lp_bad_o   = lp_bit_i && (lvl_top || (lvl_big && !big_ok_i));
    end
endmodule

// File: rtl/xec_rsvd.sv
module xec_rsvd #(
    parameter int ENTRY_W = 64,
    parameter int LEVELS  = 4,
    parameter int LVL_W   = 3
) (
    input  logic [ENTRY_W-1:0]        entry_i,
    input  logic [LVL_W-1:0]          level_i,
    input  logic [LEVELS*ENTRY_W-1:0] masks_i,
    output logic                      hit_o
);
    logic [ENTRY_W-1:0] sel_mask;

    always_comb begin
        sel_mask = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level_i == LVL_W'(l + 1)) begin
                sel_mask = masks_i[l*ENTRY_W +: ENTRY_W];
            end
        end
        hit_o = |(entry_i & sel_mask);
    end
endmodule

// File: rtl/xlat_entry_checker.sv
module xlat_entry_checker
    import xec_pkg::*;
#(
    parameter int ENTRY_W = 64,
    parameter int LEVELS  = 4,
    parameter int MT_LSB  = 3,
    parameter int MT_W    = 3,
    parameter int LP_BIT  = 7,
    parameter int SUP_BIT = 63,
    parameter bit REG_OUT = 1'b1,
    localparam int LVL_W  = $clog2(LEVELS + 1),
    localparam int MASK_W = LEVELS * ENTRY_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ENTRY_W-1:0]  entry_i,
    input  logic [LVL_W-1:0]    level_i,
    input  logic                feat_en_i,
    input  logic                big_ok_i,
    input  logic [MASK_W-1:0]   rsvd_mask_i,
    output logic [1:0]          outcome_o,
    output logic                convertible_o
);
    logic present, perm_bad;
    logic leaf_any, leaf_map, mt_bad, lp_bad, lvl_bad;
    logic rsvd_hit;
    logic miscfg;
    xec_res_t res_d, res_q;

    xec_perm u_perm (
        .perm_i     (entry_i[2:0]),
        .present_o  (present),
        .perm_bad_o (perm_bad)
    );

    xec_leaf #(
        .LEVELS   (LEVELS),
        .LVL_W    (LVL_W),
        .MT_W     (MT_W),
        .MT_LEGAL (XEC_MT_LEGAL)
    ) u_leaf (
        .level_i    (level_i),
        .lp_bit_i   (entry_i[LP_BIT]),
        .mtype_i    (entry_i[MT_LSB +: MT_W]),
        .big_ok_i   (big_ok_i),
        .leaf_any_o (leaf_any),
        .leaf_map_o (leaf_map),
        .mt_bad_o   (mt_bad),
        .lp_bad_o   (lp_bad),
        .lvl_bad_o  (lvl_bad)
    );

    xec_rsvd #(
        .ENTRY_W (ENTRY_W),
        .LEVELS  (LEVELS),
        .LVL_W   (LVL_W)
    ) u_rsvd (
        .entry_i (entry_i),
        .level_i (level_i),
        .masks_i (rsvd_mask_i),
        .hit_o   (rsvd_hit)
    );

    always_comb begin
        miscfg     = perm_bad || mt_bad || lp_bad || lvl_bad || rsvd_hit;
        res_d      = '{code: XEC_ABSENT, conv: 1'b0};
        if (!present) begin
            res_d.conv = feat_en_i && leaf_any && !entry_i[SUP_BIT];
        end else if (miscfg) begin
            res_d.code = XEC_MISCFG;
        end else if (leaf_map) begin
            res_d.code = XEC_LEAF;
        end else begin
            res_d.code = XEC_TABLE;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i) begin
                if (!rst_ni) res_q <= '{code: XEC_ABSENT, conv: 1'b0};
                else         res_q <= res_d;
            end
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    assign outcome_o     = res_q.code;
    assign convertible_o = res_q.conv;

    // R10
    absent_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !present |-> res_d.code == XEC_ABSENT);
    // R2
    perm_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (present && perm_bad) |-> res_d.code == XEC_MISCFG);
    // R4
    mtype_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (present && mt_bad) |-> res_d.code == XEC_MISCFG);
    // R5
    rsvd_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (present && rsvd_hit) |-> res_d.code == XEC_MISCFG);
    // R8
    conv_only_absent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_d.conv |-> (!present && feat_en_i && !entry_i[SUP_BIT]));
    // R9
    leaf_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_d.code == XEC_LEAF) |-> leaf_map);
endmodule

// File: tb/xlat_entry_checker_tb_top.sv
module xlat_entry_checker_tb_top;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   entry = '0;
    logic [2:0]    level = 3'd1;
    logic          feat = 1'b0;
    logic          big = 1'b0;
    logic [255:0]  masks;
    logic [1:0]    outcome;
    logic          conv;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    // L1..L3 reserve bit 62; L4 also reserves bits 6:3
    assign masks = {64'h4000_0000_0000_0078, 64'h4000_0000_0000_0000,
                    64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000};

    xlat_entry_checker dut_i (
        .clk_i(clk), .rst_ni(rst_n), .entry_i(entry), .level_i(level),
        .feat_en_i(feat), .big_ok_i(big), .rsvd_mask_i(masks),
        .outcome_o(outcome), .convertible_o(conv)
    );

    typedef struct packed {
        logic [63:0] e;
        logic [2:0]  lvl;
        logic        feat;
        logic        big;
        logic [1:0]  code;
        logic        conv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{64'h0, 3'd1, 1'b1, 1'b1, 2'd0, 1'b1, 4'd8},                  // R8 level-1 absent
        '{64'h8000_0000_0000_0000, 3'd1, 1'b1, 1'b1, 2'd0, 1'b0, 4'd8},// R8 suppressed
        '{64'h0, 3'd2, 1'b1, 1'b1, 2'd0, 1'b0, 4'd8},                  // R8 non-leaf
        '{64'h80, 3'd2, 1'b1, 1'b1, 2'd0, 1'b1, 4'd3},                 // R3 large bit leaf
        '{64'h0, 3'd1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd8},                  // R8 feature off
        '{64'h0000_0000_0000_0038, 3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd1},// R1 other bits
        '{64'h2, 3'd2, 1'b0, 1'b1, 2'd1, 1'b0, 4'd2},                  // R2 write only
        '{64'h4, 3'd4, 1'b0, 1'b1, 2'd1, 1'b0, 4'd2},                  // R2 exec only
        '{64'h6, 3'd1, 1'b0, 1'b1, 2'd1, 1'b0, 4'd2},                  // R2
        '{64'h1, 3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 4'd2},                  // R2 read only ok
        '{64'h7, 3'd4, 1'b0, 1'b1, 2'd2, 1'b0, 4'd9},                  // R9 table
        '{64'h1, 3'd3, 1'b0, 1'b1, 2'd2, 1'b0, 4'd9},                  // R9 table
        '{64'h3F, 3'd3, 1'b0, 1'b1, 2'd2, 1'b0, 4'd4},                 // R4 non-leaf ignores type
        '{64'h07, 3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 4'd4},                 // R4 type 0
        '{64'h0F, 3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 4'd4},                 // R4 type 1
        '{64'h17, 3'd1, 1'b0, 1'b1, 2'd1, 1'b0, 4'd4},                 // R4 type 2
        '{64'h1F, 3'd1, 1'b0, 1'b1, 2'd1, 1'b0, 4'd4},                 // R4 type 3
        '{64'h27, 3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 4'd4},                 // R4 type 4
        '{64'h2F, 3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 4'd4},                 // R4 type 5
        '{64'h37, 3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 4'd4},                 // R4 type 6
        '{64'h3F, 3'd1, 1'b0, 1'b1, 2'd1, 1'b0, 4'd4},                 // R4 type 7
        '{64'hB7, 3'd2, 1'b0, 1'b1, 2'd3, 1'b0, 4'd3},                 // R3 large leaf
        '{64'hBF, 3'd2, 1'b0, 1'b1, 2'd1, 1'b0, 4'd4},                 // R4 large bad type
        '{64'h87, 3'd3, 1'b0, 1'b0, 2'd1, 1'b0, 4'd6},                 // R6 large disabled
        '{64'h87, 3'd4, 1'b0, 1'b1, 2'd1, 1'b0, 4'd6},                 // R6 level 4
        '{64'h87, 3'd1, 1'b0, 1'b0, 2'd3, 1'b0, 4'd6},                 // R6 ignored at L1
        '{64'h4000_0000_0000_0003, 3'd1, 1'b0, 1'b1, 2'd1, 1'b0, 4'd5},// R5
        '{64'h4000_0000_0000_0001, 3'd2, 1'b0, 1'b1, 2'd1, 1'b0, 4'd5},// R5
        '{64'h0F, 3'd4, 1'b0, 1'b1, 2'd1, 1'b0, 4'd5},                 // R5 L4 mask
        '{64'h4000_0000_0000_0000, 3'd1, 1'b1, 1'b1, 2'd0, 1'b1, 4'd10},// R10
        '{64'h1, 3'd0, 1'b0, 1'b1, 2'd1, 1'b0, 4'd7},                  // R7 level 0
        '{64'h7, 3'd5, 1'b0, 1'b1, 2'd1, 1'b0, 4'd7}                   // R7 level 5
    };

    task automatic check(input string tag, input logic [1:0] ec, input logic ev);
        checks++;
        if (outcome !== ec || conv !== ev) begin
            errors++;
            $display("FAIL %s: outcome=%0d conv=%0b expected outcome=%0d conv=%0b",
                     tag, outcome, conv, ec, ev);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        entry = v.e; level = v.lvl; feat = v.feat; big = v.big;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11 reset holds outputs at ABSENT even with a valid entry applied
        entry = 64'h7; level = 3'd4; big = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 reset", 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", 2'd2, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].code, VECS[i].conv);
        end

        // R11 latency: new input is not visible before the next edge
        apply('{64'h07, 3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 4'd11});
        entry = 64'h2; level = 3'd1;
        #1 check("R11 hold before edge", 2'd3, 1'b0);
        @(negedge clk);
        check("R11 update after edge", 2'd1, 1'b0);

        // R8 not-present at level 3 with large bit and suppress set
        apply('{64'h8000_0000_0000_0080, 3'd3, 1'b1, 1'b1, 2'd0, 1'b0, 4'd8});
        check("R8 suppress on large", 2'd0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule